// File: doc/BRIEF.md
# Bufferless Eject and Inject Stage

This block is the first pipeline stage of a deflection router that has no buffers. In every cycle it looks at the four flit channels coming from the neighbouring routers. It may take one flit meant for this node off its channel and send it to the local core. It may then place one waiting flit from the core into a channel that is free. Whatever the channels hold after these two steps is captured in pipeline registers, and the permutation stage reads them in the next cycle.

A flit never waits inside the block. A local flit that cannot be ejected stays on its channel and is later deflected away by the next stage. A core flit that finds no free channel stays at the core, because injection ready is low. Bits [6:0] of every flit hold the destination node and bits [13:7] hold the source node. These two fields form the 14-bit header, and the payload sits above it.

Top module: `flit_xfer_stage`

## Requirements
- R1: After reset, every channel output is empty (`ch_out_vld` all zero) and `ej_valid` is low.
- R2: A valid incoming flit that is not ejected leaves on the same channel one cycle later, with all of its bits unchanged.
- R3: A flit whose bits [6:0] equal `my_node`, arriving while `ej_ready` is high, is ejected. In the next cycle `ej_valid` is high for exactly one cycle and `ej_flit` carries the whole flit, header included.
- R4: When several channels carry local flits, only the lowest-numbered one is ejected. The other local flits leave on their own channels like non-local traffic.
- R5: While `ej_ready` is low nothing is ejected, and local flits pass through as in R2.
- R6: `inj_ready` is high exactly when at least one channel is free in the current cycle. A channel is free if its input is not valid or if its flit is being ejected in this cycle.
- R7: When `inj_valid` and `inj_ready` are both high, `inj_flit` enters the lowest-numbered free channel, and that includes a channel that has just been emptied by ejection. It appears on that channel's output one cycle later.
- R8: When `inj_ready` is low, a pending `inj_flit` does not enter any channel.
- R9: Each cycle at most one flit is ejected and at most one is injected. The number of valid output channels plus `ej_valid` equals the number of valid input channels plus the injection handshake of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_node | input | 7 | Address of this node, held steady during operation |
| ch_in_vld | input | 4 | Valid flag for each incoming channel |
| ch_in_flit | input | 128 | Incoming flits, where channel i is bits [32i+31:32i] |
| ch_out_vld | output | 4 | Registered valid flag for each channel, read by the permutation stage |
| ch_out_flit | output | 128 | Registered flits, packed the same way as the inputs |
| inj_valid | input | 1 | The core has a flit to inject |
| inj_flit | input | 32 | The flit offered by the core |
| inj_ready | output | 1 | A channel is free for injection in this cycle |
| ej_ready | input | 1 | The core can take an ejected flit on the next cycle |
| ej_valid | output | 1 | Ejected flit present, high for one cycle per flit |
| ej_flit | output | 32 | The ejected flit |

## Verification
The assertions assume that `my_node` stays constant while the block runs. They also assume that a core raising `ej_ready` accepts the one-cycle `ej_valid` pulse that follows without stalling it. The bench programs a single node address after reset and changes it only between resets. It treats `ej_ready` as a plain permission bit, and it drives destinations biased toward that address so that ejection, contention between several local flits, and full channels all occur often.

// File: rtl/flit_xfer_pkg.sv
package flit_xfer_pkg;

    localparam int unsigned MAX_CH = 32;

    // Isolate the lowest set bit of a request vector (priority to index 0).
    function automatic logic [MAX_CH-1:0] lowest_one(input logic [MAX_CH-1:0] v);
        return v & (~v + 1'b1);
    endfunction

endpackage

// File: rtl/flit_eject_sel.sv
module flit_eject_sel
    import flit_xfer_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned FLIT_W = 32,
    parameter int unsigned NODE_W = 7
) (
    input  logic [NUM_CH-1:0]        vld,
    input  logic [NUM_CH*FLIT_W-1:0] flits,
    input  logic [NODE_W-1:0]        my_node,
    input  logic                     ej_ready,
    output logic [NUM_CH-1:0]        grant,
    output logic                     take,
    output logic [FLIT_W-1:0]        sel_flit
);

    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] req;
    logic [MAX_CH-1:0] pick_w;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        assign hit[g] = vld[g] && (flits[g*FLIT_W +: NODE_W] == my_node);
    end

    assign req    = ej_ready ? hit : '0;
    assign pick_w = lowest_one(MAX_CH'(req));
    assign grant  = pick_w[NUM_CH-1:0];
    assign take   = |req;

    always_comb begin
        sel_flit = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (grant[i]) begin
                sel_flit = sel_flit | flits[i*FLIT_W +: FLIT_W];
            end
        end
    end

endmodule

// File: rtl/flit_inject_sel.sv
module flit_inject_sel
    import flit_xfer_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] busy,
    output logic [NUM_CH-1:0] slot,
    output logic              any_free
);

    logic [NUM_CH-1:0] free;
    logic [MAX_CH-1:0] pick_w;

    assign free     = ~busy;
    assign pick_w   = lowest_one(MAX_CH'(free));
    assign slot     = pick_w[NUM_CH-1:0];
    assign any_free = |free;

endmodule

// File: rtl/flit_xfer_stage.sv
module flit_xfer_stage #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned FLIT_W = 32,
    parameter int unsigned NODE_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NODE_W-1:0]        my_node,
    input  logic [NUM_CH-1:0]        ch_in_vld,
    input  logic [NUM_CH*FLIT_W-1:0] ch_in_flit,
    output logic [NUM_CH-1:0]        ch_out_vld,
    output logic [NUM_CH*FLIT_W-1:0] ch_out_flit,
    input  logic                     inj_valid,
    input  logic [FLIT_W-1:0]        inj_flit,
    output logic                     inj_ready,
    input  logic                     ej_ready,
    output logic                     ej_valid,
    output logic [FLIT_W-1:0]        ej_flit
);

    localparam int unsigned BUS_W = NUM_CH * FLIT_W;

    typedef struct packed {
        logic [NUM_CH-1:0] vld;
        logic [BUS_W-1:0]  flit;
        logic              ej_vld;
        logic [FLIT_W-1:0] ej_flit;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [NUM_CH-1:0] ej_grant;
    logic              ej_take;
    logic [FLIT_W-1:0] ej_sel_flit;
    logic [NUM_CH-1:0] busy;
    logic [NUM_CH-1:0] inj_slot;
    logic              any_free;
    logic              inj_fire;

    flit_eject_sel #(
        .NUM_CH (NUM_CH),
        .FLIT_W (FLIT_W),
        .NODE_W (NODE_W)
    ) u_eject (
        .vld      (ch_in_vld),
        .flits    (ch_in_flit),
        .my_node  (my_node),
        .ej_ready (ej_ready),
        .grant    (ej_grant),
        .take     (ej_take),
        .sel_flit (ej_sel_flit)
    );

    assign busy = ch_in_vld & ~ej_grant;

    flit_inject_sel #(
        .NUM_CH (NUM_CH)
    ) u_inject (
        .busy     (busy),
        .slot     (inj_slot),
        .any_free (any_free)
    );

    assign inj_ready = any_free;
    assign inj_fire  = inj_valid && any_free;

    always_comb begin
        stage_d = stage_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (busy[i]) begin
                stage_d.vld[i]                  = 1'b1;
                stage_d.flit[i*FLIT_W +: FLIT_W] = ch_in_flit[i*FLIT_W +: FLIT_W];
            end else if (inj_fire && inj_slot[i]) begin
                stage_d.vld[i]                  = 1'b1;
                stage_d.flit[i*FLIT_W +: FLIT_W] = inj_flit;
            end else begin
                stage_d.vld[i]                  = 1'b0;
                stage_d.flit[i*FLIT_W +: FLIT_W] = '0;
            end
        end
        stage_d.ej_vld  = ej_take;
        stage_d.ej_flit = ej_take ? ej_sel_flit : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign ch_out_vld  = stage_q.vld;
    assign ch_out_flit = stage_q.flit;
    assign ej_valid    = stage_q.ej_vld;
    assign ej_flit     = stage_q.ej_flit;

endmodule

// File: rtl/flit_xfer_stage_chk.sv
module flit_xfer_stage_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned FLIT_W = 32,
    parameter int unsigned NODE_W = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NODE_W-1:0]        my_node,
    input logic [NUM_CH-1:0]        ch_in_vld,
    input logic [NUM_CH*FLIT_W-1:0] ch_in_flit,
    input logic [NUM_CH-1:0]        ch_out_vld,
    input logic [NUM_CH*FLIT_W-1:0] ch_out_flit,
    input logic                     inj_valid,
    input logic [FLIT_W-1:0]        inj_flit,
    input logic                     inj_ready,
    input logic                     ej_ready,
    input logic                     ej_valid,
    input logic [FLIT_W-1:0]        ej_flit
);

    logic seen_edge;
    always_ff @(posedge clk) begin
        seen_edge <= rst_n;
    end

    // Flit conservation across the stage
    assert_flit_count_R9: assert property (@(posedge clk) disable iff (!rst_n || !seen_edge)
        ($countones(ch_out_vld) + 32'(ej_valid)) ==
        $past($countones(ch_in_vld) + 32'(inj_valid && inj_ready)));

    // Withdrawn ejection permission means no ejected flit next cycle
    assert_no_eject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ej_ready |=> !ej_valid);

    // Anything delivered to the core is addressed to this node
    assert_eject_local_R3: assert property (@(posedge clk) disable iff (!rst_n || !seen_edge)
        ej_valid |-> (ej_flit[NODE_W-1:0] == $past(my_node)));

    // Injection only refused when every channel is occupied
    assert_refuse_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_ready |-> (&ch_in_vld));

    // Non-local traffic on channel 0 is never lost
    assert_pass_ch0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_in_vld[0] && ch_in_flit[NODE_W-1:0] != my_node) |=>
        (ch_out_vld[0] && ch_out_flit[FLIT_W-1:0] == $past(ch_in_flit[FLIT_W-1:0])));

    // Reset leaves the stage empty
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (ch_out_vld == '0 && !ej_valid));

endmodule

bind flit_xfer_stage flit_xfer_stage_chk #(
    .NUM_CH (NUM_CH),
    .FLIT_W (FLIT_W),
    .NODE_W (NODE_W)
) u_chk (.*);

// File: tb/sim_flit_xfer_stage.sv
module sim_flit_xfer_stage;

    localparam int unsigned NUM_CH = 4;
    localparam int unsigned FLIT_W = 32;
    localparam int unsigned NODE_W = 7;
    localparam time         PERIOD = 10ns;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [NODE_W-1:0]        my_node;
    logic [NUM_CH-1:0]        ch_in_vld;
    logic [NUM_CH*FLIT_W-1:0] ch_in_flit;
    logic [NUM_CH-1:0]        ch_out_vld;
    logic [NUM_CH*FLIT_W-1:0] ch_out_flit;
    logic                     inj_valid;
    logic [FLIT_W-1:0]        inj_flit;
    logic                     inj_ready;
    logic                     ej_ready;
    logic                     ej_valid;
    logic [FLIT_W-1:0]        ej_flit;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    flit_xfer_stage #(
        .NUM_CH (NUM_CH),
        .FLIT_W (FLIT_W),
        .NODE_W (NODE_W)
    ) u0 (.*);

    // Expected values from the reference model
    logic [NUM_CH-1:0] exp_vld;
    logic [FLIT_W-1:0] exp_flit [NUM_CH];
    logic              exp_ej;
    logic [FLIT_W-1:0] exp_ej_flit;
    logic              exp_rdy;

    task automatic check(input string tag, input logic [FLIT_W-1:0] act, input logic [FLIT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [FLIT_W-1:0] mk_flit(input logic [NODE_W-1:0] dst, input logic [NODE_W-1:0] src,
                                                   input logic [FLIT_W-2*NODE_W-1:0] pay);
        return {pay, src, dst};
    endfunction

    // Model computed from the requirements
    task automatic model();
        int ej_idx = -1;
        int in_idx = -1;
        logic [NUM_CH-1:0] busy;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ej_idx < 0 && ej_ready && ch_in_vld[i] &&
                ch_in_flit[i*FLIT_W +: NODE_W] == my_node) ej_idx = i;
        end
        for (int i = 0; i < NUM_CH; i++) busy[i] = ch_in_vld[i] && (i != ej_idx);
        for (int i = 0; i < NUM_CH; i++) if (in_idx < 0 && !busy[i]) in_idx = i;
        exp_rdy = (in_idx >= 0);
        exp_ej  = (ej_idx >= 0);
        exp_ej_flit = exp_ej ? ch_in_flit[ej_idx*FLIT_W +: FLIT_W] : '0;
        for (int i = 0; i < NUM_CH; i++) begin
            exp_vld[i]  = busy[i] || (inj_valid && i == in_idx);
            exp_flit[i] = busy[i] ? ch_in_flit[i*FLIT_W +: FLIT_W] : inj_flit;
        end
    endtask

    // Drive at negedge, check ready, then check registered result after posedge
    task automatic step(input string tag);
        model();
        #1;
        check({tag, " R6 inj_ready"}, 32'(inj_ready), 32'(exp_rdy));
        @(posedge clk);
        #1;
        check({tag, " R3 ej_valid"}, 32'(ej_valid), 32'(exp_ej));
        if (exp_ej) check({tag, " R3 ej_flit"}, ej_flit, exp_ej_flit);
        check({tag, " R9 ch_out_vld"}, 32'(ch_out_vld), 32'(exp_vld));
        for (int i = 0; i < NUM_CH; i++) begin
            if (exp_vld[i]) check({tag, " R2/R7 ch_out_flit"}, ch_out_flit[i*FLIT_W +: FLIT_W], exp_flit[i]);
        end
        @(negedge clk);
    endtask

    task automatic set_ch(input int i, input logic v, input logic [FLIT_W-1:0] f);
        ch_in_vld[i] = v;
        ch_in_flit[i*FLIT_W +: FLIT_W] = f;
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        rst_n = 1'b0; my_node = 7'h2A; ch_in_vld = '0; ch_in_flit = '0;
        inj_valid = 1'b0; inj_flit = '0; ej_ready = 1'b0;
        seed_val = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset ch_out_vld", 32'(ch_out_vld), 32'h0);
        check("R1 reset ej_valid", 32'(ej_valid), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: all non-local, no injection
        for (int i = 0; i < NUM_CH; i++) set_ch(i, 1'b1, mk_flit(7'h10 + 7'(i), 7'h01, 18'h3A5 + 18'(i)));
        ej_ready = 1'b1;
        step("R2 pass");

        // R4 / R7: all four local, lowest ejects, injection lands in channel 0
        for (int i = 0; i < NUM_CH; i++) set_ch(i, 1'b1, mk_flit(my_node, 7'h05, 18'h100 + 18'(i)));
        inj_valid = 1'b1; inj_flit = mk_flit(7'h33, my_node, 18'h2BEEF);
        step("R4 R7 multi-local");
        check("R7 slot ch0", ch_out_flit[FLIT_W-1:0], inj_flit);
        check("R4 ejected ch0", ej_flit, mk_flit(my_node, 7'h05, 18'h100));

        // R6 / R8: all channels non-local and full, injection refused
        for (int i = 0; i < NUM_CH; i++) set_ch(i, 1'b1, mk_flit(7'h11, 7'h22, 18'h0AA + 18'(i)));
        step("R8 full");
        check("R8 pending not taken", 32'(ch_out_vld), 32'hF);

        // R5: local flits but no permission
        ej_ready = 1'b0;
        set_ch(1, 1'b1, mk_flit(my_node, 7'h03, 18'h1111));
        set_ch(3, 1'b1, mk_flit(my_node, 7'h04, 18'h2222));
        step("R5 blocked");
        check("R5 no eject", 32'(ej_valid), 32'h0);

        // R7: local on channel 2 only, channels 0 and 1 busy, injection goes to 2
        ej_ready = 1'b1;
        set_ch(0, 1'b1, mk_flit(7'h01, 7'h02, 18'h5));
        set_ch(1, 1'b1, mk_flit(7'h01, 7'h02, 18'h6));
        set_ch(2, 1'b1, mk_flit(my_node, 7'h02, 18'h7));
        set_ch(3, 1'b1, mk_flit(7'h01, 7'h02, 18'h8));
        step("R7 reuse ejected");
        check("R7 ch2 gets injected", ch_out_flit[2*FLIT_W +: FLIT_W], inj_flit);

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            for (int i = 0; i < NUM_CH; i++) begin
                logic [NODE_W-1:0] d;
                d = ($urandom % 3 == 0) ? my_node : NODE_W'($urandom);
                set_ch(i, ($urandom % 4) != 0, mk_flit(d, NODE_W'($urandom), 18'($urandom)));
            end
            ej_ready  = ($urandom % 4) != 0;
            inj_valid = ($urandom % 2) != 0;
            inj_flit  = mk_flit(NODE_W'($urandom), my_node, 18'($urandom));
            step("R2/R3/R4/R7 random");
        end

        // R1: reset in mid-traffic clears state
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 re-reset ch_out_vld", 32'(ch_out_vld), 32'h0);
        check("R1 re-reset ej_valid", 32'(ej_valid), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule